// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block tracks control flow for one warp of `LANES` threads that execute in lockstep. It keeps a small stack of frames. Each frame holds the PC the warp resumes at, the PC where its threads rejoin their siblings, and a lane mask. The top frame always drives the fetch stage. `top_pc` and `top_mask` are combinational views of that frame.

The issue stage sends one command per cycle over a valid/ready handshake.
- An advance command moves the warp to a new PC.
- A branch command supplies a per-lane predicate, the taken target, the fall-through target and the post-dominator PC.
- When a branch splits the active lanes, the top frame is parked at the post-dominator. A frame is pushed for each side. The taken side is pushed last, so it runs first.
- When the executing frame reaches its rejoin PC, the frame is dropped. The frame below then resumes.

Control is a two-state machine:
- `ST_RUN` is the normal state.
- `ST_HALT` is entered on the transition *overflow* (a push that would exceed `DEPTH`). `ST_HALT` is left only by the transition *reset*, which returns to `ST_RUN`.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, `stack_depth` is 1, `top_pc` equals `RESET_PC`, `top_mask` has every lane bit set, and `overflow` is 0.
- R2: An accepted advance (`cmd_op`=0) whose `cmd_next_pc` differs from the top frame's rejoin PC sets `top_pc` to `cmd_next_pc` and leaves the mask and depth unchanged.
- R3: An accepted advance whose target equals the top frame's rejoin PC, with `stack_depth` > 1, removes the top frame. The frame below then drives `top_pc` and `top_mask`.
- R4: An accepted branch (`cmd_op`=1) is divergent when the active lanes contain both predicate 1 (taken) and predicate 0. Bit i of `cmd_pred` and of `top_mask` refers to lane i. A divergent branch raises the depth by 2. The new top runs `cmd_taken_pc` with mask `cmd_pred & top_mask`.
- R5: When the taken side reaches the rejoin PC, the fall-through frame runs next. That frame has PC `cmd_next_pc` and mask `~cmd_pred & top_mask`.
- R6: When the fall-through side also reaches the rejoin PC, the parent frame resumes at the post-dominator PC with its original mask and depth.
- R7: A branch whose predicate is uniform over the active lanes pushes nothing. It sets `top_pc` to the taken target if any lane is taken, and otherwise to the fall-through target. Predicate bits of inactive lanes have no effect.
- R8: In a divergent branch, a side whose target already equals the post-dominator PC is not pushed, so the depth rises by 1.
- R9: A branch needing more pushes than the free entries sets `overflow` and leaves `top_pc`, `top_mask` and `stack_depth` unchanged.
- R10: Once set, `overflow` stays high until reset. Every later command has no effect on `top_pc`, `top_mask` or `stack_depth`.
- R11: The bottom frame is never removed. An advance at depth 1 only updates `top_pc`, even to the all-ones PC.
- R12: A command presented with `cmd_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 1 | 0 = advance, 1 = branch |
| cmd_pred | input | LANES | Per-lane taken predicate |
| cmd_taken_pc | input | PC_W | Branch taken target |
| cmd_next_pc | input | PC_W | Advance target / branch fall-through target |
| cmd_rpc | input | PC_W | Post-dominator (rejoin) PC of the branch |
| top_pc | output | PC_W | PC the warp fetches next |
| top_mask | output | LANES | Lanes active for that PC |
| stack_depth | output | $clog2(DEPTH+1) | Number of valid frames |
| overflow | output | 1 | Sticky stack overflow error |

## Verification
Branches are driven with four kinds of predicate:
- An even 0011 split, where both sides run in turn and rejoin. This separates correct push order from swapped order.
- An all-taken predicate and an all-not-taken predicate. These show that uniform branches push nothing.
- A predicate set only on inactive lanes inside a nested path. This shows that masking happens before the divergence test.
- A split whose fall-through target is the post-dominator. This distinguishes the single push from a double push.

A nested split near full depth exercises the overflow and freeze paths. Advances to the all-ones PC at depth 1 and an unaccepted command round out the cases.

// File: rtl/simt_pkg.sv
package simt_pkg;

    typedef enum logic {
        OP_ADVANCE = 1'b0,
        OP_BRANCH  = 1'b1
    } cmd_op_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } ctl_state_t;

endpackage

// File: rtl/simt_path_split.sv
module simt_path_split #(
    parameter int LANES = 4,
    parameter int PC_W  = 16
) (
    input  logic [LANES-1:0] act_mask,
    input  logic [LANES-1:0] pred,
    input  logic [PC_W-1:0]  taken_pc,
    input  logic [PC_W-1:0]  next_pc,
    input  logic [PC_W-1:0]  rpc,
    output logic [LANES-1:0] take_mask,
    output logic [LANES-1:0] fall_mask,
    output logic             diverge,
    output logic             need_take,
    output logic             need_fall,
    output logic [1:0]       push_n,
    output logic [PC_W-1:0]  single_pc
);
    always_comb begin
        take_mask = pred & act_mask;
        fall_mask = ~pred & act_mask;
        diverge   = (|take_mask) && (|fall_mask);
        need_take = diverge && (taken_pc != rpc);
        need_fall = diverge && (next_pc != rpc);
        push_n    = {1'b0, need_take} + {1'b0, need_fall};
        single_pc = (|take_mask) ? taken_pc : next_pc;
    end
endmodule

// File: rtl/simt_frame_file.sv
module simt_frame_file #(
    parameter int LANES    = 4,
    parameter int PC_W     = 16,
    parameter int DEPTH    = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int DW      = $clog2(DEPTH + 1),
    localparam int IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_top,
    input  logic [PC_W-1:0]  set_pc,
    input  logic             pop,
    input  logic [1:0]       push_n,
    input  logic [PC_W-1:0]  push_rpc,
    input  logic [PC_W-1:0]  p0_pc,
    input  logic [LANES-1:0] p0_mask,
    input  logic [PC_W-1:0]  p1_pc,
    input  logic [LANES-1:0] p1_mask,
    output logic [PC_W-1:0]  top_pc,
    output logic [PC_W-1:0]  top_rpc,
    output logic [LANES-1:0] top_mask,
    output logic [DW-1:0]    depth
);
    logic [PC_W-1:0]  pc_q   [DEPTH];
    logic [PC_W-1:0]  rpc_q  [DEPTH];
    logic [LANES-1:0] mask_q [DEPTH];
    logic [DW-1:0]    depth_q;
    logic [DW-1:0]    slot_hi;
    logic [IW-1:0]    top_idx;

    assign top_idx = IW'(depth_q - DW'(1));
    assign slot_hi = depth_q + DW'(1);

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    pc_q[i]   <= (i == 0) ? RESET_PC : '0;
                    rpc_q[i]  <= '1;
                    mask_q[i] <= (i == 0) ? '1 : '0;
                end else begin
                    if (set_top && (IW'(i) == top_idx))
                        pc_q[i] <= set_pc;
                    if ((push_n != 2'd0) && (DW'(i) == depth_q)) begin
                        pc_q[i]   <= p0_pc;
                        rpc_q[i]  <= push_rpc;
                        mask_q[i] <= p0_mask;
                    end
                    if ((push_n == 2'd2) && (DW'(i) == slot_hi)) begin
                        pc_q[i]   <= p1_pc;
                        rpc_q[i]  <= push_rpc;
                        mask_q[i] <= p1_mask;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) depth_q <= DW'(1);
        else     depth_q <= depth_q + DW'(push_n) - DW'(pop);
    end

    assign top_pc   = pc_q[top_idx];
    assign top_rpc  = rpc_q[top_idx];
    assign top_mask = mask_q[top_idx];
    assign depth    = depth_q;
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PC_W  = 16,
    parameter int DEPTH = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_op,
    input  logic [LANES-1:0] cmd_pred,
    input  logic [PC_W-1:0]  cmd_taken_pc,
    input  logic [PC_W-1:0]  cmd_next_pc,
    input  logic [PC_W-1:0]  cmd_rpc,
    output logic [PC_W-1:0]  top_pc,
    output logic [LANES-1:0] top_mask,
    output logic [DW-1:0]    stack_depth,
    output logic             overflow
);
    ctl_state_t state_q, state_d;

    logic [PC_W-1:0]  top_rpc;
    logic [LANES-1:0] take_mask, fall_mask;
    logic             diverge, need_take, need_fall;
    logic [1:0]       push_n;
    logic [PC_W-1:0]  single_pc;

    logic             accept, is_branch, room_ok;
    logic             set_top, pop, ovf_evt;
    logic [PC_W-1:0]  set_pc, path_pc;
    logic [1:0]       do_push;
    logic [PC_W-1:0]  p0_pc;
    logic [LANES-1:0] p0_mask;

    simt_path_split #(.LANES(LANES), .PC_W(PC_W)) u_split (
        .act_mask (top_mask),
        .pred     (cmd_pred),
        .taken_pc (cmd_taken_pc),
        .next_pc  (cmd_next_pc),
        .rpc      (cmd_rpc),
        .take_mask(take_mask),
        .fall_mask(fall_mask),
        .diverge  (diverge),
        .need_take(need_take),
        .need_fall(need_fall),
        .push_n   (push_n),
        .single_pc(single_pc)
    );

    simt_frame_file #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(RESET_PC)) u_frames (
        .clk     (clk),
        .rst     (rst),
        .set_top (set_top),
        .set_pc  (set_pc),
        .pop     (pop),
        .push_n  (do_push),
        .push_rpc(cmd_rpc),
        .p0_pc   (p0_pc),
        .p0_mask (p0_mask),
        .p1_pc   (cmd_taken_pc),
        .p1_mask (take_mask),
        .top_pc  (top_pc),
        .top_rpc (top_rpc),
        .top_mask(top_mask),
        .depth   (stack_depth)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    assign cmd_ready = 1'b1;
    assign accept    = cmd_valid && cmd_ready;
    assign is_branch = (cmd_op_t'(cmd_op) == OP_BRANCH);
    assign room_ok   = ({1'b0, stack_depth} + (DW+1)'(push_n)) <= (DW+1)'(DEPTH);
    assign path_pc   = is_branch ? single_pc : cmd_next_pc;
    assign p0_pc     = need_fall ? cmd_next_pc : cmd_taken_pc;
    assign p0_mask   = need_fall ? fall_mask : take_mask;

    // next state and stack controls
    always_comb begin
        state_d = state_q;
        set_top = 1'b0;
        set_pc  = path_pc;
        pop     = 1'b0;
        do_push = 2'd0;
        ovf_evt = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (accept) begin
                    if (is_branch && diverge) begin
                        if (room_ok) begin
                            set_top = 1'b1;
                            set_pc  = cmd_rpc;
                            do_push = push_n;
                        end else begin
                            ovf_evt = 1'b1;
                            state_d = ST_HALT;
                        end
                    end else if ((path_pc == top_rpc) && (stack_depth > DW'(1))) begin
                        pop = 1'b1;
                    end else begin
                        set_top = 1'b1;
                    end
                end
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:  overflow = 1'b0;
            ST_HALT: overflow = 1'b1;
            default: overflow = 1'b0;
        endcase
    end

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (stack_depth >= DW'(1)) && (stack_depth <= DW'(DEPTH)));

    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R10
    halt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> ($stable(top_pc) && $stable(top_mask) && $stable(stack_depth)));

    // R4
    diverge_push_chk: assert property (@(posedge clk) disable iff (rst)
        (!overflow && accept && is_branch && need_take && need_fall && room_ok)
        |=> (stack_depth == $past(stack_depth) + DW'(2)));

    // R3
    pop_depth_chk: assert property (@(posedge clk) disable iff (rst)
        pop |=> (stack_depth == $past(stack_depth) - DW'(1)));

    // R7
    mask_live_chk: assert property (@(posedge clk) disable iff (rst)
        top_mask != '0);

    // R9
    ovf_evt_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ($stable(stack_depth) && overflow));
endmodule

// File: tb/simt_reconv_stack_test.sv
module simt_reconv_stack_test;
    localparam int LANES = 4;
    localparam int PC_W  = 16;
    localparam int DEPTH = 4;
    localparam int DW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             cmd_valid;
    logic             cmd_ready;
    logic             cmd_op;
    logic [LANES-1:0] cmd_pred;
    logic [PC_W-1:0]  cmd_taken_pc, cmd_next_pc, cmd_rpc;
    logic [PC_W-1:0]  top_pc;
    logic [LANES-1:0] top_mask;
    logic [DW-1:0]    stack_depth;
    logic             overflow;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(16'h0000)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_pred(cmd_pred), .cmd_taken_pc(cmd_taken_pc),
        .cmd_next_pc(cmd_next_pc), .cmd_rpc(cmd_rpc), .top_pc(top_pc),
        .top_mask(top_mask), .stack_depth(stack_depth), .overflow(overflow)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic see(input string req, input logic [15:0] pc, input logic [3:0] m,
                       input int d, input logic ov);
        chk(req, "pc", 32'(top_pc), 32'(pc));
        chk(req, "mask", 32'(top_mask), 32'(m));
        chk(req, "depth", 32'(stack_depth), 32'(d));
        chk(req, "overflow", 32'(overflow), 32'(ov));
    endtask

    task automatic send(input logic v, input logic op, input logic [3:0] p,
                        input logic [15:0] tk, input logic [15:0] nx, input logic [15:0] rp);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_pred = p;
        cmd_taken_pc = tk; cmd_next_pc = nx; cmd_rpc = rp;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic adv(input logic [15:0] nx);
        send(1'b1, 1'b0, 4'h0, 16'h0, nx, 16'h0);
    endtask

    task automatic br(input logic [3:0] p, input logic [15:0] tk, input logic [15:0] nx, input logic [15:0] rp);
        send(1'b1, 1'b1, p, tk, nx, rp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        see("R1", 16'h0000, 4'hF, 1, 1'b0);
        chk("R1", "ready", 32'(cmd_ready), 32'd1);
    endtask

    task automatic t_advance();
        adv(16'h0010);
        see("R2", 16'h0010, 4'hF, 1, 1'b0);
        adv(16'hFFFF);
        see("R11", 16'hFFFF, 4'hF, 1, 1'b0);
        adv(16'h0020);
        see("R2", 16'h0020, 4'hF, 1, 1'b0);
    endtask

    task automatic t_diverge();
        br(4'b0011, 16'h0040, 16'h0030, 16'h0050);
        see("R4", 16'h0040, 4'b0011, 3, 1'b0);
        adv(16'h0044);
        see("R2", 16'h0044, 4'b0011, 3, 1'b0);
        adv(16'h0050);
        see("R5", 16'h0030, 4'b1100, 2, 1'b0);
        adv(16'h0050);
        see("R6", 16'h0050, 4'hF, 1, 1'b0);
    endtask

    task automatic t_uniform();
        br(4'b1111, 16'h0060, 16'h0058, 16'h0070);
        see("R7", 16'h0060, 4'hF, 1, 1'b0);
        br(4'b0000, 16'h0068, 16'h0064, 16'h0070);
        see("R7", 16'h0064, 4'hF, 1, 1'b0);
        br(4'b0101, 16'h0080, 16'h0090, 16'h00A0);
        see("R4", 16'h0080, 4'b0101, 3, 1'b0);
        br(4'b1010, 16'h0088, 16'h0084, 16'h008C);
        see("R7", 16'h0084, 4'b0101, 3, 1'b0);
        adv(16'h00A0);
        see("R3", 16'h0090, 4'b1010, 2, 1'b0);
        adv(16'h00A0);
        see("R6", 16'h00A0, 4'hF, 1, 1'b0);
    endtask

    task automatic t_rpc_target();
        br(4'b0011, 16'h00B0, 16'h00C0, 16'h00C0);
        see("R8", 16'h00B0, 4'b0011, 2, 1'b0);
        adv(16'h00C0);
        see("R8", 16'h00C0, 4'hF, 1, 1'b0);
    endtask

    task automatic t_novalid();
        send(1'b0, 1'b0, 4'h0, 16'h0, 16'h1234, 16'h0);
        see("R12", 16'h00C0, 4'hF, 1, 1'b0);
        send(1'b0, 1'b1, 4'b0110, 16'h2000, 16'h3000, 16'h4000);
        see("R12", 16'h00C0, 4'hF, 1, 1'b0);
    endtask

    task automatic t_overflow();
        br(4'b0011, 16'h0100, 16'h0200, 16'h0300);
        see("R4", 16'h0100, 4'b0011, 3, 1'b0);
        br(4'b0001, 16'h0110, 16'h0120, 16'h0130);
        see("R9", 16'h0100, 4'b0011, 3, 1'b1);
        adv(16'h0999);
        see("R10", 16'h0100, 4'b0011, 3, 1'b1);
        adv(16'h0300);
        see("R10", 16'h0100, 4'b0011, 3, 1'b1);
        do_reset();
        see("R1", 16'h0000, 4'hF, 1, 1'b0);
    endtask

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 1'b0; cmd_pred = '0;
        cmd_taken_pc = '0; cmd_next_pc = '0; cmd_rpc = '0;
        t_reset();
        t_advance();
        t_diverge();
        t_uniform();
        t_rpc_target();
        t_novalid();
        t_overflow();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule